// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers a set of level-sensitive interrupt lines, organised as `N_WORDS` words of 32 lines each, and drives one combined interrupt output per CPU. Every CPU owns a private register bank that holds its own mask. One CPU can therefore enable a different subset of the same lines than another CPU. A CPU's output is raised while at least one line is high and unmasked in that CPU's bank.

Software reaches the banks over a simple single-cycle 32-bit bus with byte addresses. Each bank has four groups of `N_WORDS` words, in a fixed order. The first group returns the raw line levels. The second returns the current mask. The third sets mask bits when a 1 is written. The fourth clears mask bits when a 1 is written. The banks sit at a power-of-two stride just above the bank span, and the address bits above that stride select the CPU. Read data appears on the bus one cycle after the request.

Top module: `banked_level_irq_ctrl`

## Requirements
- R1: Interrupt line n is reported in status word n/32 at bit position n%32.
- R2: Within a bank, word w of group g sits at byte offset (g*N_WORDS + w)*4. Groups are numbered 0 = raw status, 1 = mask readback, 2 = mask set, 3 = mask clear. Bank c starts at byte address c * 2^ceil(log2(16*N_WORDS)).
- R3: After reset, every mask bit of every bank reads 1 and every CPU output is 0.
- R4: Writing a 1 to a bit of a mask-set word masks that line for that CPU only.
- R5: Writing a 1 to a bit of a mask-clear word unmasks that line for that CPU only.
- R6: A 0 bit written to a mask-set or mask-clear word leaves the corresponding mask bit unchanged.
- R7: A read of a raw status word returns the input levels present at the request cycle. The value is the same from every bank and appears on the read data port one cycle after the request.
- R8: A read of a mask readback word returns that CPU's current mask word.
- R9: Each CPU output is a register. In the cycle after any input is high with its mask bit 0 in that bank, the output is 1. In the cycle after no such line exists, the output is 0.
- R10: A mask write addressed to one CPU's bank does not change any other bank's mask or output.
- R11: Writes to raw status or mask readback words change nothing. Reads of mask-set and mask-clear words return 0.
- R12: One access is taken per cycle. When a set and a clear on the same bit arrive in consecutive cycles, the later access decides the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_WORDS*32 | Level-sensitive interrupt lines |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request, 0 otherwise |
| irq_out | output | N_CPUS | Per-CPU combined interrupt |

## Verification
Read data is due one clock edge after the edge that accepts the read. A mask write changes the mask on its accepting edge, so the CPU outputs reflect it one edge later, two edges after the request. A change on the interrupt inputs reaches the outputs on the very next edge. The driver stamps each expected item with the cycle count at which the result is due. The monitor compares items only in that cycle, on the falling edge, and writes are followed by idle cycles so that no input change overlaps a pending output expectation.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int unsigned LINE_BITS = 32;

   // register group order inside one CPU bank; the offset of each group
   // depends on this order
   typedef enum logic [1:0] {
      GRP_RAW    = 2'd0,
      GRP_MASKRD = 2'd1,
      GRP_MSET   = 2'd2,
      GRP_MCLR   = 2'd3
   } grp_e;
endpackage

// File: rtl/irqagg_addr_dec.sv
module irqagg_addr_dec
   import irqagg_pkg::*;
#(
   parameter int N_WORDS = 2,
   parameter int N_CPUS  = 2,
   parameter int ADDR_W  = 8,
   localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_CPUS-1:0] cpu_hit,
   output grp_e              grp,
   output logic [WSEL_W-1:0] wsel
);
   localparam int BANK_AW = $clog2(16 * N_WORDS);
   localparam int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1;
   localparam int IDX_W   = BANK_AW - 2;
   localparam int TOP_LSB = BANK_AW + CPU_W;

   logic [IDX_W-1:0] idx;
   logic [CPU_W-1:0] cpu_f;
   logic             upper_ok;
   logic [31:0]      gnum;
   logic             unused_lsb;

   assign idx        = addr[BANK_AW-1:2];
   assign cpu_f      = addr[TOP_LSB-1:BANK_AW];
   assign unused_lsb = ^addr[1:0];

   generate
      if (ADDR_W > TOP_LSB) begin : g_upper
         assign upper_ok = (addr[ADDR_W-1:TOP_LSB] == '0);
      end else begin : g_noupper
         assign upper_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      gnum = 32'(idx) / 32'(N_WORDS);
      grp  = grp_e'(gnum[1:0]);
      wsel = WSEL_W'(32'(idx) % 32'(N_WORDS));
      for (int c = 0; c < N_CPUS; c++) begin
         cpu_hit[c] = upper_ok && (gnum < 32'd4) && (cpu_f == CPU_W'(c));
      end
   end
endmodule

// File: rtl/irqagg_cpu_bank.sv
module irqagg_cpu_bank
   import irqagg_pkg::*;
#(
   parameter int N_WORDS = 2,
   localparam int TOT    = N_WORDS * LINE_BITS,
   localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TOT-1:0]    irq_in,
   input  logic              wr_en,
   input  grp_e              grp,
   input  logic [WSEL_W-1:0] wsel,
   input  logic [31:0]       wdata,
   output logic [TOT-1:0]    mask_q,
   output logic [31:0]       mask_word,
   output logic              irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wr_en) begin
         for (int w = 0; w < N_WORDS; w++) begin
            if (wsel == WSEL_W'(w)) begin
               if (grp == GRP_MSET)
                  mask_q[w*LINE_BITS +: LINE_BITS] <= mask_q[w*LINE_BITS +: LINE_BITS] | wdata;
               else if (grp == GRP_MCLR)
                  mask_q[w*LINE_BITS +: LINE_BITS] <= mask_q[w*LINE_BITS +: LINE_BITS] & ~wdata;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(irq_in & ~mask_q);
   end

   always_comb begin
      mask_word = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         if (wsel == WSEL_W'(w)) mask_word = mask_q[w*LINE_BITS +: LINE_BITS];
      end
   end
endmodule

// File: rtl/banked_level_irq_ctrl.sv
module banked_level_irq_ctrl
   import irqagg_pkg::*;
#(
   parameter int N_WORDS = 2,
   parameter int N_CPUS  = 2,
   parameter int ADDR_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_WORDS*LINE_BITS-1:0] irq_in,
   input  logic                        bus_valid,
   input  logic                        bus_write,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   output logic [N_CPUS-1:0]           irq_out
);
   localparam int TOT     = N_WORDS * LINE_BITS;
   localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam int BANK_AW = $clog2(16 * N_WORDS);
   localparam int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1;

   generate
      if (N_WORDS < 1 || N_WORDS > 5) begin : g_bad_words
         $error("N_WORDS must lie in 1..5");
      end
      if (N_CPUS < 1 || N_CPUS > 4) begin : g_bad_cpus
         $error("N_CPUS must lie in 1..4");
      end
      if (ADDR_W < BANK_AW + CPU_W) begin : g_bad_addr
         $error("ADDR_W too narrow for bank and CPU fields");
      end
   endgenerate

   logic [N_CPUS-1:0]     cpu_hit;
   grp_e                  dec_grp;
   logic [WSEL_W-1:0]     dec_wsel;
   logic                  hit_any;
   logic [31:0]           bank_word [N_CPUS];
   logic [N_CPUS*TOT-1:0] mask_all;
   logic [31:0]           raw_word;
   logic [31:0]           sel_mask;
   logic [31:0]           rd_word;

   irqagg_addr_dec #(
      .N_WORDS(N_WORDS), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)
   ) dec_i (
      .addr(bus_addr), .cpu_hit(cpu_hit), .grp(dec_grp), .wsel(dec_wsel)
   );

   assign hit_any = |cpu_hit;

   generate
      for (genvar c = 0; c < N_CPUS; c++) begin : g_bank
         irqagg_cpu_bank #(.N_WORDS(N_WORDS)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in),
            .wr_en    (bus_valid && bus_write && cpu_hit[c]),
            .grp      (dec_grp),
            .wsel     (dec_wsel),
            .wdata    (bus_wdata),
            .mask_q   (mask_all[c*TOT +: TOT]),
            .mask_word(bank_word[c]),
            .irq_q    (irq_out[c])
         );
      end
   endgenerate

   always_comb begin
      raw_word = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         if (dec_wsel == WSEL_W'(w)) raw_word = irq_in[w*LINE_BITS +: LINE_BITS];
      end
      sel_mask = '0;
      for (int c = 0; c < N_CPUS; c++) begin
         if (cpu_hit[c]) sel_mask = sel_mask | bank_word[c];
      end
      unique case (dec_grp)
         GRP_RAW:    rd_word = raw_word;
         GRP_MASKRD: rd_word = sel_mask;
         default:    rd_word = '0;
      endcase
      if (!hit_any) rd_word = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      bus_rdata <= '0;
      else if (bus_valid && !bus_write) bus_rdata <= rd_word;
      else                             bus_rdata <= '0;
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
   parameter int N_WORDS = 2,
   parameter int N_CPUS  = 2,
   localparam int TOT    = N_WORDS * 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TOT-1:0]        irq_in,
   input logic [N_CPUS-1:0]     irq_out,
   input logic                  bus_valid,
   input logic                  bus_write,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [1:0]            dec_grp,
   input logic                  dec_hit,
   input logic [N_CPUS*TOT-1:0] mask_all
);
   // R3
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (irq_out == '0 && mask_all == '1);
      end
   end

   // R6
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_wdata == '0) |=> $stable(mask_all));

   // R11
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !dec_grp[1]) |=> $stable(mask_all));

   // R11
   strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && dec_hit && dec_grp[1]) |=> (bus_rdata == '0));

   // R9
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in == '0) |=> (irq_out == '0));

   generate
      for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
         // R9
         pending_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(irq_in & ~mask_all[c*TOT +: TOT])) |=> irq_out[c]);
      end
   endgenerate
endmodule

bind banked_level_irq_ctrl irqagg_chk #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_in   (irq_in),
   .irq_out  (irq_out),
   .bus_valid(bus_valid),
   .bus_write(bus_write),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .dec_grp  (dec_grp),
   .dec_hit  (hit_any),
   .mask_all (mask_all)
);

// File: tb/banked_level_irq_ctrl_tb_top.sv
module banked_level_irq_ctrl_tb_top;
   localparam int NW  = 2;
   localparam int NC  = 2;
   localparam int AW  = 8;
   localparam int TOT = NW * 32;
   localparam int BAW = $clog2(16 * NW);

   logic           clk = 1'b0;
   logic           rst_n;
   logic [TOT-1:0] irq_in;
   logic           bus_valid, bus_write;
   logic [AW-1:0]  bus_addr;
   logic [31:0]    bus_wdata, bus_rdata;
   logic [NC-1:0]  irq_out;

   always #2 clk = ~clk;

   banked_level_irq_ctrl #(.N_WORDS(NW), .N_CPUS(NC), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   typedef struct {
      int          due;
      bit          is_rd;
      int          cpu;
      logic [31:0] exp;
      string       req;
   } exp_t;

   exp_t           sb[$];
   int             cyc = 0;
   int             n_chk = 0;
   int             n_fail = 0;
   bit             done = 0;
   logic [31:0]    m_mask [NC][NW];
   logic [TOT-1:0] m_in;

   always @(posedge clk) cyc++;

   function automatic logic [AW-1:0] reg_addr(int c, int g, int w);
      return AW'((c << BAW) + (g * NW + w) * 4);
   endfunction

   function automatic logic exp_irq(int c);
      logic r = 1'b0;
      for (int w = 0; w < NW; w++) r |= |(m_in[w*32 +: 32] & ~m_mask[c][w]);
      return r;
   endfunction

   task automatic push(int d, bit rd, int c, logic [31:0] e, string rq);
      exp_t it;
      it.due = cyc + d; it.is_rd = rd; it.cpu = c; it.exp = e; it.req = rq;
      sb.push_back(it);
   endtask

   task automatic push_outs(int d, string rq);
      for (int c = 0; c < NC; c++) push(d, 1'b0, c, {31'b0, exp_irq(c)}, rq);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         bus_valid = 1'b0; bus_write = 1'b0;
      end
   endtask

   task automatic bus_rd(int c, int g, int w, logic [31:0] e, string rq);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = reg_addr(c, g, w);
      push(1, 1'b1, 0, e, rq);
   endtask

   task automatic bus_wr(int c, int g, int w, logic [31:0] d, string rq);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = reg_addr(c, g, w); bus_wdata = d;
      if (g == 2) m_mask[c][w] = m_mask[c][w] | d;
      if (g == 3) m_mask[c][w] = m_mask[c][w] & ~d;
      push_outs(2, rq);
   endtask

   task automatic set_in(logic [TOT-1:0] v, string rq);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      irq_in = v; m_in = v;
      push_outs(1, rq);
   endtask

   // scoreboard monitor: compares each item in the cycle it is due
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            logic [31:0] act;
            act = sb[i].is_rd ? bus_rdata : {31'b0, irq_out[sb[i].cpu]};
            n_chk++;
            if (act !== sb[i].exp) begin
               n_fail++;
               $display("FAIL %s %s cpu%0d actual=%h expected=%h", sb[i].req,
                        sb[i].is_rd ? "rdata" : "irq_out", sb[i].cpu, act, sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; irq_in = '0; m_in = '0;
      bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
      for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) m_mask[c][w] = '1;
      repeat (3) @(negedge clk);
      n_chk++;
      if (irq_out !== '0 || bus_rdata !== '0) begin
         n_fail++;
         $display("FAIL R3 reset outputs actual=%b/%h expected=0/0", irq_out, bus_rdata);
      end
      rst_n = 1'b1;
      // R3: every mask bit starts at 1
      for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) bus_rd(c, 1, w, 32'hffff_ffff, "R3");
      // R1: line 37 shows in word 1 bit 5
      set_in(TOT'(1) << 37, "R1");
      bus_rd(0, 0, 1, 32'h0000_0020, "R1");
      bus_rd(1, 0, 1, 32'h0000_0020, "R7");
      bus_rd(0, 0, 0, 32'h0, "R7");
      // R5 / R10: unmask line 37 for cpu0 only
      bus_wr(0, 3, 1, 32'h0000_0020, "R5");
      idle(2);
      bus_rd(0, 1, 1, ~32'h0000_0020, "R8");
      bus_rd(1, 1, 1, 32'hffff_ffff, "R10");
      // R6: zero write to set word changes nothing
      bus_wr(0, 2, 1, 32'h0, "R6");
      bus_rd(0, 1, 1, ~32'h0000_0020, "R6");
      // R11: writes to read-only groups ignored, strobe words read 0
      bus_wr(0, 0, 1, 32'hffff_ffff, "R11");
      bus_wr(0, 1, 1, 32'hffff_ffff, "R11");
      idle(2);
      bus_rd(0, 1, 1, ~32'h0000_0020, "R11");
      bus_rd(0, 2, 1, 32'h0, "R11");
      bus_rd(1, 3, 0, 32'h0, "R11");
      // R2: cpu1 bank clear word 0 at its own offset
      bus_wr(1, 3, 0, 32'h0000_00ff, "R2");
      idle(2);
      bus_rd(1, 1, 0, 32'hffff_ff00, "R2");
      bus_rd(0, 1, 0, 32'hffff_ffff, "R10");
      // R9: input changes reach outputs one edge later
      idle(1);
      set_in(TOT'(1) << 3, "R9");
      set_in('0, "R9");
      set_in((TOT'(1) << 3) | (TOT'(1) << 37), "R9");
      idle(1);
      // R4: mask line 37 again for cpu0
      bus_wr(0, 2, 1, 32'h0000_0030, "R4");
      idle(2);
      bus_rd(0, 1, 1, 32'hffff_ffff, "R4");
      // R12: later access wins
      bus_wr(1, 2, 0, 32'h0000_0008, "R12");
      bus_wr(1, 3, 0, 32'h0000_0008, "R12");
      idle(2);
      bus_rd(1, 1, 0, 32'hffff_ff00, "R12");
      bus_wr(1, 3, 0, 32'h0000_0008, "R12");
      bus_wr(1, 2, 0, 32'h0000_0008, "R12");
      idle(2);
      bus_rd(1, 1, 0, 32'hffff_ff08, "R12");
      idle(4);
      done = 1;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule